// File: doc/BRIEF.md
# Word-to-Pixel Unpacker for a Parallel Panel Bus

This block sits between a pixel FIFO that delivers 32-bit memory words and the data pins of a parallel display panel. Each time the timing logic raises a pixel strobe, the unpacker emits exactly one pixel. The pixel comes either from the word it is already holding or, once that word is used up, from the word at the head of the FIFO.

Three configuration fields control the unpacking:
- A per-byte-lane mask marks which bytes of each word carry pixel data.
- A word-length code sets the size of a stored pixel: 2 or 3 bytes.
- A bus-width code maps each pixel onto a 16-, 8-, 18- or 24-bit panel bus.

With all four lanes enabled and 2-byte pixels, one word yields two pixels. With only the three low lanes enabled and 3-byte pixels, one word yields exactly one pixel and the top byte is dropped.

A flush input discards the rest of a partly used word. Software raises it after reprogramming, so the image does not start shifted.

Top module: `pixel_word_unpacker`

## Requirements
- R1: After reset `pix_valid`, `underflow` and `pix_data` are 0, and `in_ready` stays low while `pix_strobe` is low.
- R2: The bytes of a word whose `cfg_lane_mask` bit is set (bit i covers `in_word[8i+7:8i]`) are packed together in ascending lane order. Disabled lanes are dropped.
- R3: `cfg_word_len` value 3 gives 3-byte pixels; any other value gives 2-byte pixels. A word yields floor(enabled lanes / pixel bytes) pixels, with a minimum of one. Missing bytes of a short pixel read as zero.
- R4: Within a word, pixels come out from the lowest packed byte upward, so the lower half-word comes before the upper half-word.
- R5: `in_ready` is high only in a cycle with `pix_strobe` high, `fifo_clear` low and no pixel left in the held word. The word accepted in that cycle supplies the pixel for that strobe. Later pixels of the word come from the held copy, whatever `in_word` shows.
- R6: A served strobe updates `pix_data` and raises `pix_valid` at the next clock edge. `pix_valid` is low for one cycle after any cycle without a served strobe.
- R7: A strobe with no pixel left and `in_valid` low raises `underflow` for one cycle, leaves `pix_valid` low and holds `pix_data`.
- R8: `fifo_clear` discards the remaining pixels of the held word. A strobe in the same cycle is ignored: no output, no pop, no underflow. The next strobe pops a new word.
- R9: `cfg_bus_code` 0 (16-bit bus) drives {8'h0, pixel[15:0]}. Code 1 (8-bit bus) drives {16'h0, pixel[7:0]}.
- R10: Code 2 (18-bit bus) drives {6'h0, p[23:18], p[15:10], p[7:2]} for 3-byte pixels, keeping the top 6 bits of each colour byte. For 2-byte pixels it drives {8'h0, p[15:0]}.
- R11: Code 3 (24-bit bus) drives the 3-byte pixel whole, or {8'h0, p[15:0]} for 2-byte pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bus_code | input | 2 | Panel bus width: 0=16, 1=8, 2=18, 3=24 bits |
| cfg_word_len | input | 2 | Stored pixel size: 3 selects 3 bytes, others 2 bytes |
| cfg_lane_mask | input | LANES | Byte lanes of each word that carry pixel data |
| fifo_clear | input | 1 | Discard the rest of the held word |
| in_word | input | 8*LANES | Word at the FIFO head |
| in_valid | input | 1 | FIFO head holds a word |
| in_ready | output | 1 | Head word is taken this cycle |
| pix_strobe | input | 1 | A pixel is due |
| pix_data | output | 24 | Pixel on the panel bus |
| pix_valid | output | 1 | `pix_data` was updated by the last strobe |
| underflow | output | 1 | A strobe found no data |

## Verification
A wrong held-word index or pixel count shows at the ports on the very next strobe:
- A wrong index or count makes `in_ready` rise one strobe early or late.
- The same fault makes the following `pix_data` carry the wrong half-word or the wrong word entirely.

A stale "pixels left" state after a flush shows as a missing pop, or as a pixel taken from the discarded word, one cycle after the first strobe that follows the flush. Lane packing and bus mapping faults appear in `pix_data` one cycle after the strobe that emitted the pixel. The sweep covers every lane mask, both pixel sizes and all four bus codes.

// File: rtl/pwu_pkg.sv
package pwu_pkg;
  localparam int PIX_W = 24;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    BUS_16 = 2'd0,
    BUS_8  = 2'd1,
    BUS_18 = 2'd2,
    BUS_24 = 2'd3
  } bus_code_e;

  localparam logic [1:0] WLEN_3BYTE = 2'd3;
endpackage

// File: rtl/pwu_lane_compact.sv
module pwu_lane_compact #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0]          word_i,
  input  logic [LANES-1:0]            mask_i,
  input  logic                        wide_i,
  output logic [LANES*8-1:0]          packed_o,
  output logic [$clog2(LANES+1)-1:0]  npix_o
);
  localparam int CNT_W = $clog2(LANES+1);

  logic [CNT_W-1:0] pop;
  logic [CNT_W-1:0] quot;

  // pack enabled lanes toward the low end
  always_comb begin
    packed_o = '0;
    pop      = '0;
    for (int i = 0; i < LANES; i++) begin
      if (mask_i[i]) begin
        packed_o[int'(pop)*8 +: 8] = word_i[i*8 +: 8];
        pop = pop + 1'b1;
      end
    end
  end

  always_comb begin
    quot   = wide_i ? CNT_W'(pop / 3) : CNT_W'(pop / 2);
    npix_o = (quot == '0) ? CNT_W'(1) : quot;
  end
endmodule

// File: rtl/pwu_pix_map.sv
module pwu_pix_map
  import pwu_pkg::*;
(
  input  logic [PIX_W-1:0] pix_i,
  input  logic             wide_i,
  input  logic [1:0]       bus_i,
  output logic [PIX_W-1:0] bus_o
);
  logic [PIX_W-1:0] narrow;

  assign narrow = {8'h00, pix_i[15:0]};

  always_comb begin
    case (bus_code_e'(bus_i))
      BUS_8:   bus_o = {16'h0000, pix_i[7:0]};
      BUS_18:  bus_o = wide_i ? {6'h00, pix_i[23:18], pix_i[15:10], pix_i[7:2]} : narrow;
      BUS_24:  bus_o = wide_i ? pix_i : narrow;
      default: bus_o = narrow;
    endcase
  end
endmodule

// File: rtl/pixel_word_unpacker.sv
module pixel_word_unpacker
  import pwu_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           cfg_bus_code,
  input  logic [1:0]           cfg_word_len,
  input  logic [LANES-1:0]     cfg_lane_mask,
  input  logic                 fifo_clear,
  input  logic [LANES*8-1:0]   in_word,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 pix_strobe,
  output logic [PIX_W-1:0]     pix_data,
  output logic                 pix_valid,
  output logic                 underflow
);
  localparam int WORD_W = LANES * 8;
  localparam int CNT_W  = $clog2(LANES+1);

  logic              wide;
  logic [WORD_W-1:0] comp_in;
  logic [CNT_W-1:0]  npix_in;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              have_q;
  logic [WORD_W-1:0] src;
  logic [CNT_W-1:0]  sel_idx;
  logic [7:0]        shamt;
  logic [WORD_W-1:0] shifted;
  logic [PIX_W-1:0]  raw_pix;
  logic [PIX_W-1:0]  bus_pix;
  logic [CNT_W-1:0]  idx_nxt;

  assign wide = (cfg_word_len == WLEN_3BYTE);

  pwu_lane_compact #(.LANES(LANES)) u_compact (
    .word_i   (in_word),
    .mask_i   (cfg_lane_mask),
    .wide_i   (wide),
    .packed_o (comp_in),
    .npix_o   (npix_in)
  );

  // pixel source: held word while pixels remain, else FIFO head
  assign src     = have_q ? word_q : comp_in;
  assign sel_idx = have_q ? idx_q : '0;
  assign shamt   = wide ? 8'(sel_idx) * 8'd24 : 8'(sel_idx) * 8'd16;
  assign shifted = src >> shamt;
  assign raw_pix = wide ? shifted[PIX_W-1:0] : {8'h00, shifted[15:0]};
  assign idx_nxt = idx_q + 1'b1;

  pwu_pix_map u_map (
    .pix_i  (raw_pix),
    .wide_i (wide),
    .bus_i  (cfg_bus_code),
    .bus_o  (bus_pix)
  );

  assign in_ready = pix_strobe && !fifo_clear && !have_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q    <= '0;
      idx_q     <= '0;
      cnt_q     <= '0;
      have_q    <= 1'b0;
      pix_data  <= '0;
      pix_valid <= 1'b0;
      underflow <= 1'b0;
    end else begin
      pix_valid <= 1'b0;
      underflow <= 1'b0;
      if (fifo_clear) begin
        have_q <= 1'b0;
        idx_q  <= '0;
      end else if (pix_strobe) begin
        if (have_q) begin
          pix_data  <= bus_pix;
          pix_valid <= 1'b1;
          idx_q     <= idx_nxt;
          have_q    <= (idx_nxt < cnt_q);
        end else if (in_valid) begin
          pix_data  <= bus_pix;
          pix_valid <= 1'b1;
          word_q    <= comp_in;
          cnt_q     <= npix_in;
          idx_q     <= CNT_W'(1);
          have_q    <= (npix_in > CNT_W'(1));
        end else begin
          underflow <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwu_checker.sv
module pwu_checker (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  cfg_bus_code,
  input logic        fifo_clear,
  input logic        in_valid,
  input logic        in_ready,
  input logic        pix_strobe,
  input logic [23:0] pix_data,
  input logic        pix_valid,
  input logic        underflow
);
  AST_READY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (pix_strobe && !fifo_clear)); // R5

  AST_POP_GIVES_PIXEL: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> pix_valid); // R5

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> ($past(pix_strobe) && !$past(fifo_clear))); // R6

  AST_UNDERFLOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
    underflow |-> (!pix_valid && $stable(pix_data))); // R7

  AST_CLEAR_SILENT: assert property (@(posedge clk) disable iff (rst)
    fifo_clear |=> (!pix_valid && !underflow)); // R8

  AST_BYTE_BUS_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(cfg_bus_code) == 2'd1) |-> (pix_data[23:8] == 16'h0)); // R9

  AST_18_BUS_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(cfg_bus_code) == 2'd2) |-> (pix_data[23:18] == 6'h0)); // R10
endmodule

bind pixel_word_unpacker pwu_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_bus_code (cfg_bus_code),
  .fifo_clear   (fifo_clear),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .pix_strobe   (pix_strobe),
  .pix_data     (pix_data),
  .pix_valid    (pix_valid),
  .underflow    (underflow)
);

// File: tb/pixel_word_unpacker_tb.sv
module pixel_word_unpacker_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  cfg_bus_code;
  logic [1:0]  cfg_word_len;
  logic [3:0]  cfg_lane_mask;
  logic        fifo_clear;
  logic [31:0] in_word;
  logic        in_valid;
  logic        in_ready;
  logic        pix_strobe;
  logic [23:0] pix_data;
  logic        pix_valid;
  logic        underflow;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pixel_word_unpacker #(.LANES(4)) u_dut (
    .clk(clk), .rst(rst), .cfg_bus_code(cfg_bus_code), .cfg_word_len(cfg_word_len),
    .cfg_lane_mask(cfg_lane_mask), .fifo_clear(fifo_clear), .in_word(in_word),
    .in_valid(in_valid), .in_ready(in_ready), .pix_strobe(pix_strobe),
    .pix_data(pix_data), .pix_valid(pix_valid), .underflow(underflow)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int npx(input logic [3:0] m, input logic [1:0] wl);
    int pop = 0;
    int bpp = (wl == 2'd3) ? 3 : 2;
    for (int i = 0; i < 4; i++) if (m[i]) pop++;
    return (pop / bpp == 0) ? 1 : pop / bpp;
  endfunction

  function automatic logic [23:0] model(input logic [31:0] w, input logic [3:0] m,
                                        input logic [1:0] wl, input logic [1:0] bus, input int k);
    logic [31:0] c = 32'h0;
    int pos = 0;
    int bpp = (wl == 2'd3) ? 3 : 2;
    logic [31:0] s;
    logic [23:0] p;
    for (int i = 0; i < 4; i++) begin
      if (m[i]) begin
        c[pos*8 +: 8] = w[i*8 +: 8];
        pos++;
      end
    end
    s = c >> (k * bpp * 8);
    p = s[23:0];
    if (bpp == 2) p[23:16] = 8'h00;
    case (bus)
      2'd1: return {16'h0, p[7:0]};
      2'd2: return (bpp == 3) ? {6'h0, p[23:18], p[15:10], p[7:2]} : {8'h0, p[15:0]};
      2'd3: return (bpp == 3) ? p : {8'h0, p[15:0]};
      default: return {8'h0, p[15:0]};
    endcase
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    logic [23:0] last;
    string tag;
    int n;
    rst = 1'b1; cfg_bus_code = 2'd0; cfg_word_len = 2'd0; cfg_lane_mask = 4'hF;
    fifo_clear = 1'b0; in_word = 32'h0; in_valid = 1'b0; pix_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    #1;
    // R1 reset state
    check({31'h0, pix_valid}, 32'h0, "R1 pix_valid");
    check({31'h0, underflow}, 32'h0, "R1 underflow");
    check({8'h0, pix_data}, 32'h0, "R1 pix_data");
    check({31'h0, in_ready}, 32'h0, "R1 in_ready");

    // sweep: bus code x pixel size x lane mask
    for (int bus = 0; bus < 4; bus++) begin
      for (int wsel = 0; wsel < 2; wsel++) begin
        for (int m = 1; m < 16; m++) begin
          cfg_bus_code  = 2'(bus);
          cfg_word_len  = (wsel == 1) ? 2'd3 : 2'd0;
          cfg_lane_mask = 4'(m);
          tag = (bus == 2) ? "R10" : (bus == 3) ? "R11" : "R9";
          w = {8'(m*17 + bus), 8'(8'hA5 ^ 8'(m)), 8'((m << 4) | wsel), 8'(8'h3C + bus*9)};
          // R8 flush with simultaneous strobe is ignored
          fifo_clear = 1'b1; pix_strobe = 1'b1; in_valid = 1'b1; in_word = w;
          #1 check({31'h0, in_ready}, 32'h0, "R8 ready during clear");
          step();
          check({30'h0, pix_valid, underflow}, 32'h0, "R8 silent after clear");
          fifo_clear = 1'b0;
          n = npx(4'(m), cfg_word_len);
          for (int k = 0; k < n; k++) begin
            pix_strobe = 1'b1; in_valid = 1'b1;
            in_word = (k == 0) ? w : ~w;
            #1 check({31'h0, in_ready}, {31'h0, k == 0}, "R5 ready only at pop");
            step();
            check({31'h0, pix_valid}, 32'h1, "R6 pix_valid");
            check({8'h0, pix_data}, {8'h0, model(w, 4'(m), cfg_word_len, 2'(bus), k)},
                  {"R2/R3/R4/", tag, " pixel"});
          end
          last = pix_data;
          // R7 underflow when word used up and FIFO empty
          pix_strobe = 1'b1; in_valid = 1'b0;
          #1 check({31'h0, in_ready}, 32'h1, "R5 ready after last pixel");
          step();
          check({30'h0, underflow, pix_valid}, 32'h2, "R7 underflow pulse");
          check({8'h0, pix_data}, {8'h0, last}, "R7 data held");
          pix_strobe = 1'b0;
          step();
          check({30'h0, underflow, pix_valid}, 32'h0, "R6 idle without strobe");
        end
      end
    end

    // R8 mid-word flush then new word
    cfg_bus_code = 2'd3; cfg_word_len = 2'd0; cfg_lane_mask = 4'hF;
    pix_strobe = 1'b1; in_valid = 1'b1; in_word = 32'hAAAA_1111;
    step();
    check({8'h0, pix_data}, 32'h0000_1111, "R4 lower half first");
    pix_strobe = 1'b0; fifo_clear = 1'b1;
    step();
    fifo_clear = 1'b0; pix_strobe = 1'b1; in_word = 32'h5555_2222;
    #1 check({31'h0, in_ready}, 32'h1, "R8 pop after flush");
    step();
    check({8'h0, pix_data}, 32'h0000_2222, "R8 new word after flush");
    pix_strobe = 1'b0;
    step();
    finish_run();
  end
endmodule